// File: doc/BRIEF.md
# Resource Reservation Conflict Checker

This block keeps a bit matrix that records which machine resources are already booked at each future time step. The rows are time steps and the columns are resources. An issue stage presents an instruction class and a candidate start row. The block answers at once whether that instruction can start there without contending for any resource it needs. When the issue stage decides to place the instruction, it pulses a commit strobe, and the block books the instruction's resource usage into the matrix.

Each instruction class carries a fixed usage pattern that spans four consecutive time steps. Legality is found by masking every step of that pattern against the matrix row at the start row plus the step's offset. A single overlapping bit makes the start illegal. The booking merges the pattern into the same window. A clear input empties the whole matrix so that a new schedule can begin. Dependence tracking and the choice of which instruction to issue are left to the surrounding logic.

Top module: `rt_conflict_checker`

## Requirements
- R1: After reset or a clear, every entry of the matrix is zero, so every query whose window fits inside the matrix is legal.
- R2: The built-in usage patterns are as follows, with step s counted from the start row. Class 0 uses resource 0 at step 0, resource 1 at steps 1 and 2, and resource 2 at step 3. Class 1 uses resource 0 at step 0, resource 3 at step 1, and resource 4 at steps 2 and 3. Class 2 uses resource 5 at steps 0 and 1. Class 3 uses no resource.
- R3: `legal_o` is a combinational function of the current query and the current matrix, and is valid in the same cycle as the query.
- R4: A query at row t is legal only if, for every step s from 0 to 3, the class pattern at step s ANDed with matrix row t+s gives zero.
- R5: A commit made while the query is legal and clear is low merges the class pattern into rows t to t+3 on the next clock edge.
- R6: A commit made while the query is illegal leaves the matrix unchanged, and `commit_err_o` is high for exactly the following cycle.
- R7: A query with a start row greater than DEPTH-4 is illegal, whatever the class, and a commit of such a query is treated as in R6.
- R8: When clear and commit are high in the same cycle, the clear wins: the matrix is emptied, the commit is dropped, and no error is raised.
- R9: With the default patterns, class 0 and class 1 at equal start rows conflict on resource 0. Class 0 at rows t and t+1 conflicts on resource 1. Class 0 at row t followed by class 1 at row t+1 does not conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Empty the whole matrix on the next edge |
| qry_class_i | input | CLS_W | Instruction class of the query |
| qry_row_i | input | ROW_W | Candidate start row of the query |
| commit_i | input | 1 | Book the queried instruction into the matrix |
| legal_o | output | 1 | Query fits and has no resource overlap |
| commit_err_o | output | 1 | Previous cycle's commit was refused |

## Verification
The bench builds the block with DEPTH set to 12 and NUM_RES set to 6. The start row then takes values from 0 to 15, so rows 9 to 11 are reachable. These rows sit just past the last legal start, and their windows run off the end of the matrix. Rows 12 to 15 lie wholly beyond the matrix. Random query, commit and clear sequences on this small matrix fill it to the point where most queries are refused. This exercises refused commits and clears that land in the same cycle as a commit. A software matrix built independently of the RTL predicts every answer and every error flag.

// File: rtl/rt_pkg.sv
package rt_pkg;

    localparam int STEPS       = 4;
    localparam int NUM_CLASSES = 4;
    localparam int PAT_W       = 8;
    localparam int CLASS_EMPTY = 3;

    typedef logic [PAT_W-1:0] pat_t;

    // Resource usage of one class at one step of its window.
    function automatic pat_t class_step_use(input int cls, input int step);
        pat_t p;
        p = '0;
        case (cls)
            0: begin
                if (step == 0)               p[0] = 1'b1;
                if (step == 1 || step == 2)  p[1] = 1'b1;
                if (step == 3)               p[2] = 1'b1;
            end
            1: begin
                if (step == 0)               p[0] = 1'b1;
                if (step == 1)               p[3] = 1'b1;
                if (step == 2 || step == 3)  p[4] = 1'b1;
            end
            2: begin
                if (step == 0 || step == 1)  p[5] = 1'b1;
            end
            default: p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/rt_class_rom.sv
module rt_class_rom
    import rt_pkg::*;
#(
    parameter int NUM_RES = 6,
    parameter int CLS_W   = 2
) (
    input  logic [CLS_W-1:0]                 cls_i,
    output logic [STEPS-1:0][NUM_RES-1:0]    pat_o
);

    for (genvar s = 0; s < STEPS; s++) begin : g_step
        always_comb begin
            pat_o[s] = NUM_RES'(class_step_use(int'(cls_i), s));
        end
    end

endmodule

// File: rtl/rt_window_check.sv
module rt_window_check
    import rt_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int NUM_RES = 6,
    parameter int ROW_W   = 4
) (
    input  logic [DEPTH-1:0][NUM_RES-1:0]    tbl_i,
    input  logic [ROW_W-1:0]                 row_i,
    input  logic [STEPS-1:0][NUM_RES-1:0]    pat_i,
    output logic                             fits_o,
    output logic                             clash_o
);

    localparam int LAST_START = DEPTH - STEPS;

    always_comb begin
        fits_o = (int'(row_i) <= LAST_START);
    end

    // Each matrix row is compared with the step that would land on it.
    always_comb begin
        clash_o = 1'b0;
        for (int r = 0; r < DEPTH; r++) begin
            for (int s = 0; s < STEPS; s++) begin
                if (int'(row_i) + s == r) begin
                    clash_o = clash_o | (|(tbl_i[r] & pat_i[s]));
                end
            end
        end
    end

endmodule

// File: rtl/rt_table_merge.sv
module rt_table_merge
    import rt_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int NUM_RES = 6,
    parameter int ROW_W   = 4
) (
    input  logic [DEPTH-1:0][NUM_RES-1:0]    tbl_i,
    input  logic [ROW_W-1:0]                 row_i,
    input  logic [STEPS-1:0][NUM_RES-1:0]    pat_i,
    output logic [DEPTH-1:0][NUM_RES-1:0]    tbl_o
);

    for (genvar r = 0; r < DEPTH; r++) begin : g_row
        logic [NUM_RES-1:0] add_bits;
        always_comb begin
            add_bits = '0;
            for (int s = 0; s < STEPS; s++) begin
                if (int'(row_i) + s == r) begin
                    add_bits = add_bits | pat_i[s];
                end
            end
            tbl_o[r] = tbl_i[r] | add_bits;
        end
    end

endmodule

// File: rtl/rt_conflict_checker.sv
module rt_conflict_checker
    import rt_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int NUM_RES = 6,
    parameter int ROW_W   = $clog2(DEPTH),
    parameter int CLS_W   = $clog2(NUM_CLASSES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [CLS_W-1:0] qry_class_i,
    input  logic [ROW_W-1:0] qry_row_i,
    input  logic             commit_i,
    output logic             legal_o,
    output logic             commit_err_o
);

    typedef logic [DEPTH-1:0][NUM_RES-1:0] table_t;

    typedef struct packed {
        table_t tbl;
        logic   err;
    } state_t;

    state_t st_d, st_q;

    logic [STEPS-1:0][NUM_RES-1:0] pat;
    logic                          fits;
    logic                          clash;
    table_t                        merged;
    logic                          legal;

    rt_class_rom #(
        .NUM_RES (NUM_RES),
        .CLS_W   (CLS_W)
    ) u_rom (
        .cls_i (qry_class_i),
        .pat_o (pat)
    );

    rt_window_check #(
        .DEPTH   (DEPTH),
        .NUM_RES (NUM_RES),
        .ROW_W   (ROW_W)
    ) u_check (
        .tbl_i   (st_q.tbl),
        .row_i   (qry_row_i),
        .pat_i   (pat),
        .fits_o  (fits),
        .clash_o (clash)
    );

    rt_table_merge #(
        .DEPTH   (DEPTH),
        .NUM_RES (NUM_RES),
        .ROW_W   (ROW_W)
    ) u_merge (
        .tbl_i (st_q.tbl),
        .row_i (qry_row_i),
        .pat_i (pat),
        .tbl_o (merged)
    );

    always_comb begin
        legal = fits & ~clash;
        st_d  = st_q;
        st_d.err = 1'b0;
        if (clr_i) begin
            st_d.tbl = '0;
        end else if (commit_i) begin
            if (legal) begin
                st_d.tbl = merged;
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign legal_o      = legal;
    assign commit_err_o = st_q.err;

endmodule

// File: rtl/rt_conflict_checker_chk.sv
module rt_conflict_checker_chk
    import rt_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int NUM_RES = 6,
    parameter int ROW_W   = 4,
    parameter int CLS_W   = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_i,
    input logic [CLS_W-1:0] qry_class_i,
    input logic [ROW_W-1:0] qry_row_i,
    input logic             commit_i,
    input logic             legal_o,
    input logic             commit_err_o
);

    localparam int LAST_START = DEPTH - STEPS;

    // R7
    out_of_range_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(qry_row_i) > LAST_START) |-> !legal_o);

    // R1
    empty_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr_i) && int'(qry_row_i) <= LAST_START) |-> legal_o);

    // R6
    refused_commit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !legal_o && !clr_i) |=> commit_err_o);

    // R6
    flag_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_err_o |-> $past(commit_i && !legal_o && !clr_i));

    // R8
    clear_drops_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !commit_err_o);

    // R5
    booked_query_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(commit_i && legal_o && !clr_i && int'(qry_class_i) != CLASS_EMPTY)
         && $stable(qry_class_i) && $stable(qry_row_i)) |-> !legal_o);

endmodule

bind rt_conflict_checker rt_conflict_checker_chk #(
    .DEPTH   (DEPTH),
    .NUM_RES (NUM_RES),
    .ROW_W   (ROW_W),
    .CLS_W   (CLS_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_i        (clr_i),
    .qry_class_i  (qry_class_i),
    .qry_row_i    (qry_row_i),
    .commit_i     (commit_i),
    .legal_o      (legal_o),
    .commit_err_o (commit_err_o)
);

// File: tb/tb_rt_conflict_checker.sv
`timescale 1ns/1ps
module tb_rt_conflict_checker;

    localparam int DEPTH   = 12;
    localparam int NUM_RES = 6;
    localparam int ROW_W   = 4;
    localparam int CLS_W   = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clr_i = 1'b0;
    logic [CLS_W-1:0] qry_class_i = '0;
    logic [ROW_W-1:0] qry_row_i = '0;
    logic             commit_i = 1'b0;
    logic             legal_o;
    logic             commit_err_o;

    always #2.5 clk = ~clk;

    rt_conflict_checker #(
        .DEPTH   (DEPTH),
        .NUM_RES (NUM_RES)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (clr_i),
        .qry_class_i  (qry_class_i),
        .qry_row_i    (qry_row_i),
        .commit_i     (commit_i),
        .legal_o      (legal_o),
        .commit_err_o (commit_err_o)
    );

    typedef struct {
        bit    legal;
        bit    err;
        string req;
    } item_t;

    item_t         sb_q[$];
    event          ev_sample;
    int            checks = 0;
    int            fails  = 0;
    bit [NUM_RES-1:0] mdl [DEPTH];
    bit            err_pend = 1'b0;

    // Usage patterns written from R2.
    function automatic bit [NUM_RES-1:0] usage(input int c, input int s);
        bit [NUM_RES-1:0] u = '0;
        if (c == 0 && s == 0) u[0] = 1;
        if (c == 0 && (s == 1 || s == 2)) u[1] = 1;
        if (c == 0 && s == 3) u[2] = 1;
        if (c == 1 && s == 0) u[0] = 1;
        if (c == 1 && s == 1) u[3] = 1;
        if (c == 1 && s >= 2) u[4] = 1;
        if (c == 2 && s <= 1) u[5] = 1;
        return u;
    endfunction

    function automatic bit model_legal(input int c, input int r);
        if (r + 4 > DEPTH) return 1'b0;
        for (int s = 0; s < 4; s++) begin
            if ((mdl[r+s] & usage(c, s)) != '0) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic step(input int c, input int r, input bit com, input bit clr, input string req);
        item_t it;
        bit    l;
        @(negedge clk);
        qry_class_i = CLS_W'(c);
        qry_row_i   = ROW_W'(r);
        commit_i    = com;
        clr_i       = clr;
        l = model_legal(c, r);
        it.legal = l;
        it.err   = err_pend;
        it.req   = req;
        sb_q.push_back(it);
        -> ev_sample;
        err_pend = 1'b0;
        if (clr) begin
            for (int k = 0; k < DEPTH; k++) mdl[k] = '0;
        end else if (com) begin
            if (l) begin
                for (int s = 0; s < 4; s++) mdl[r+s] = mdl[r+s] | usage(c, s);
            end else begin
                err_pend = 1'b1;
            end
        end
    endtask

    // Monitor: compares the outputs in the cycle of each query.
    initial begin
        item_t it;
        forever begin
            @(ev_sample);
            #1;
            it = sb_q.pop_front();
            checks++;
            if (legal_o !== it.legal) begin
                fails++;
                $display("FAIL %s legal_o actual=%0b expected=%0b", it.req, legal_o, it.legal);
            end
            checks++;
            if (commit_err_o !== it.err) begin
                fails++;
                $display("FAIL %s commit_err_o actual=%0b expected=%0b", it.req, commit_err_o, it.err);
            end
        end
    end

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < DEPTH; k++) mdl[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state: empty matrix
        step(0, 0, 0, 0, "R1");
        step(1, 5, 0, 0, "R1");
        // R7 boundary rows
        step(3, DEPTH-4, 0, 0, "R7");
        step(3, DEPTH-3, 0, 0, "R7");
        step(0, 15, 0, 0, "R7");
        // R5 booking, R3 same-cycle answer
        step(0, 2, 1, 0, "R5");
        step(0, 2, 0, 0, "R3");
        // R9 pairwise conflicts
        step(1, 2, 0, 0, "R9");
        step(1, 3, 0, 0, "R9");
        step(0, 3, 0, 0, "R9");
        step(2, 2, 0, 0, "R2");
        // R6 refused commit leaves matrix as it was
        step(1, 2, 1, 0, "R6");
        step(1, 3, 0, 0, "R6");
        step(0, 9, 1, 0, "R7");
        step(3, 0, 0, 0, "R7");
        // R8 clear beats commit
        step(0, 0, 1, 1, "R8");
        step(0, 2, 0, 0, "R8");
        step(0, 0, 0, 0, "R8");
        // R2 empty class and two-step class
        step(3, 0, 1, 0, "R2");
        step(3, 0, 0, 0, "R2");
        step(2, 5, 1, 0, "R2");
        step(2, 6, 0, 0, "R2");
        step(2, 7, 0, 0, "R2");
        step(2, 4, 0, 0, "R2");

        // R4 random sequences against the model
        for (int n = 0; n < 3000; n++) begin
            int c, r;
            bit com, clr;
            c   = int'($urandom_range(0, 3));
            r   = int'($urandom_range(0, 15));
            com = ($urandom_range(0, 1) == 1);
            clr = ($urandom_range(0, 49) == 0);
            step(c, r, com, clr, "R4");
        end

        step(3, 0, 0, 0, "R6");
        @(negedge clk);
        #2;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule